// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind the serial command decoder of a byte-addressed non-volatile store. During a write transaction the decoder hands it a start address and then a run of data bytes. Each byte goes into a small page buffer at the current offset inside the page, and a per-offset mask records that the offset was loaded. The decoder can also hand over a status-register byte instead.

When chip select is released on a whole byte boundary and something was loaded, the block runs a self-timed programming cycle. It holds a busy flag for a fixed number of clocks and commits the status byte and every loaded offset, lowest offset first, through one-byte store strobes. When the cycle ends it emits a one-clock pulse that clears the write-enable latch kept elsewhere. A release in the middle of a byte, or with nothing loaded, throws the transaction away. While a cycle runs, all load and release strobes are ignored.

Top module: `pgw_sequencer`

## Requirements
- R1: After reset `busy_o`, `wel_clr_o`, `mem_we_o` and `sr_we_o` are all 0.
- R2: A start strobe sets the page from `addr_i[12:5]` and the load offset from `addr_i[4:0]`. Each committed byte carries that page in `mem_addr_o[12:5]`.
- R3: The offset advances by one after every loaded byte and wraps from 31 to 0 inside the same page. A later byte at an already loaded offset replaces the earlier one.
- R4: During a cycle, exactly the loaded offsets are committed, one per clock, in ascending offset order. The first store strobe comes in the second busy cycle.
- R5: A cycle starts only from a release (`cs_rise_i`) with `partial_i` low and at least one loaded byte or status byte. `busy_o` is 1 in the clock after that release.
- R6: A release with `partial_i` high starts no cycle and gives no `wel_clr_o` pulse. It discards the loaded data, so a later bare release starts nothing.
- R7: A release after a start strobe with no data byte starts no cycle.
- R8: `busy_o` stays high for exactly `CYCLE_CLKS` clocks.
- R9: `wel_clr_o` pulses for one clock, in the first clock after `busy_o` falls, and at no other time.
- R10: A captured status byte is presented on `sr_wdata_o` with a one-clock `sr_we_o` in the first busy cycle.
- R11: Start, byte, status and release strobes that arrive while `busy_o` is 1 have no effect.
- R12: `mem_we_o` and `sr_we_o` are only high while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_page_i | input | 1 | Start of a data transaction; captures `addr_i` |
| addr_i | input | ADDR_W | Start address (page and offset) |
| ld_byte_i | input | 1 | One whole data byte received |
| data_i | input | 8 | Data byte |
| ld_sr_i | input | 1 | One status-register byte received |
| sr_data_i | input | 8 | Status byte |
| cs_rise_i | input | 1 | Chip select released (one-clock pulse) |
| partial_i | input | 1 | Release happened in the middle of a byte |
| busy_o | output | 1 | Programming cycle in progress |
| wel_clr_o | output | 1 | One-clock pulse that clears the write-enable latch |
| mem_we_o | output | 1 | Store strobe for one byte |
| mem_addr_o | output | ADDR_W | Store byte address |
| mem_wdata_o | output | 8 | Store byte data |
| sr_we_o | output | 1 | Status-register store strobe |
| sr_wdata_o | output | 8 | Status-register store data |

## Verification
The checker watches, on every clock, that store strobes stay inside the busy window and that busy rises only after a clean release. It also checks that the busy window lasts exactly the configured length, that the latch-clear pulse lines up with busy falling, and that consecutive stores climb by one offset inside one page. Only the bench scenarios can show the rest: which offsets are committed and with what data after a wrap and overwrite, that aborted or empty transactions leave nothing pending, and that strobes sent during a cycle are really dropped.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PROG = 1'b1
  } pgw_state_t;
endpackage

// File: rtl/pgw_buffer.sv
`timescale 1ns/1ps
// Page buffer: one synchronous write port, one registered read port (RAM friendly).
module pgw_buffer #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgw_timer.sv
`timescale 1ns/1ps
// Cycle timer: runs for LEN clocks after start, done is high in the last one.
module pgw_timer #(
  parameter int LEN = 400000,
  localparam int TW = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  logic          run_q;
  logic [TW-1:0] cnt_q;

  assign done = run_q && (cnt_q == TW'(LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (done) run_q <= 1'b0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pgw_sequencer.sv
`timescale 1ns/1ps
// Page write buffer and self-timed commit sequencer.
// PAGE_BYTES must be a power of two so the offset wraps inside the page.
module pgw_sequencer
  import pgw_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int ADDR_W     = 13,
  parameter int CYCLE_CLKS = 400000,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_page_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ld_byte_i,
  input  logic [7:0]        data_i,
  input  logic              ld_sr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              cs_rise_i,
  input  logic              partial_i,
  output logic              busy_o,
  output logic              wel_clr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              sr_we_o,
  output logic [7:0]        sr_wdata_o
);
  pgw_state_t             state_q;
  logic [PAGE_W-1:0]      page_q;
  logic [OFF_W-1:0]       off_q;
  logic [PAGE_BYTES-1:0]  mask_q;
  logic                   sr_pend_q;
  logic [7:0]             sr_hold_q;
  logic [OFF_W-1:0]       scan_q;
  logic                   scan_on_q;
  logic                   idle;
  logic                   go;
  logic                   drop;
  logic                   done;
  logic                   buf_we;

  assign idle   = (state_q == ST_IDLE);
  assign go     = idle && cs_rise_i && !partial_i && ((|mask_q) || sr_pend_q);
  assign drop   = idle && cs_rise_i && !go;
  assign buf_we = idle && ld_byte_i && !ld_page_i;

  pgw_buffer #(.DEPTH(PAGE_BYTES), .DW(8)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (off_q),
    .wdata (data_i),
    .raddr (scan_q),
    .rdata (mem_wdata_o)
  );

  pgw_timer #(.LEN(CYCLE_CLKS)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (go),
    .done  (done)
  );

  // Loading side: page, offset, loaded mask and status byte.
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q    <= '0;
      off_q     <= '0;
      mask_q    <= '0;
      sr_pend_q <= 1'b0;
      sr_hold_q <= '0;
    end else if (idle) begin
      if (drop) begin
        mask_q    <= '0;
        sr_pend_q <= 1'b0;
      end else if (ld_page_i) begin
        page_q    <= addr_i[ADDR_W-1:OFF_W];
        off_q     <= addr_i[OFF_W-1:0];
        mask_q    <= '0;
        sr_pend_q <= 1'b0;
      end else if (ld_byte_i) begin
        mask_q[off_q] <= 1'b1;
        off_q         <= off_q + 1'b1;
      end else if (ld_sr_i) begin
        sr_pend_q <= 1'b1;
        sr_hold_q <= sr_data_i;
      end
    end else if (done) begin
      mask_q    <= '0;
      sr_pend_q <= 1'b0;
    end
  end

  // Cycle side: state, scan of the loaded offsets, registered strobes.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      scan_q     <= '0;
      scan_on_q  <= 1'b0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      sr_we_o    <= 1'b0;
      sr_wdata_o <= '0;
      wel_clr_o  <= 1'b0;
    end else begin
      wel_clr_o <= done;
      sr_we_o   <= go && sr_pend_q;
      if (go) sr_wdata_o <= sr_hold_q;
      mem_we_o  <= 1'b0;
      if (go) begin
        state_q   <= ST_PROG;
        scan_q    <= '0;
        scan_on_q <= 1'b1;
      end else if (!idle) begin
        if (done) state_q <= ST_IDLE;
        if (scan_on_q) begin
          mem_we_o   <= mask_q[scan_q];
          mem_addr_o <= {page_q, scan_q};
          scan_q     <= scan_q + 1'b1;
          if (scan_q == OFF_W'(PAGE_BYTES - 1)) scan_on_q <= 1'b0;
        end
      end
    end
  end

  assign busy_o = (state_q == ST_PROG);
endmodule

// File: rtl/pgw_sequencer_chk.sv
`timescale 1ns/1ps
module pgw_sequencer_chk #(
  parameter int PAGE_BYTES = 32,
  parameter int ADDR_W     = 13,
  parameter int CYCLE_CLKS = 400000,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_rise_i,
  input logic              partial_i,
  input logic              busy_o,
  input logic              wel_clr_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              sr_we_o
);
  int unsigned bcnt;

  always_ff @(posedge clk) begin
    if (rst)         bcnt <= 0;
    else if (busy_o) bcnt <= bcnt + 1;
    else             bcnt <= 0;
  end

  initial begin
    assert_cycle_len_R4: assert (CYCLE_CLKS >= PAGE_BYTES + 1)
      else $error("cycle too short for a full page scan");
  end

  assert_store_in_busy_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o || sr_we_o) |-> busy_o);

  assert_start_clean_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(cs_rise_i) && !$past(partial_i)));

  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (bcnt < CYCLE_CLKS));

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(bcnt) == CYCLE_CLKS - 1));

  assert_wel_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> wel_clr_o);

  assert_wel_only_fall_R9: assert property (@(posedge clk) disable iff (rst)
    wel_clr_o |-> (!busy_o && $past(busy_o)));

  assert_ascending_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[OFF_W-1:0] == $past(mem_addr_o[OFF_W-1:0]) + 1'b1));

  assert_same_page_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_addr_o[ADDR_W-1:OFF_W] == $past(mem_addr_o[ADDR_W-1:OFF_W])));
endmodule

bind pgw_sequencer pgw_sequencer_chk #(
  .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
  .clk(clk), .rst(rst), .cs_rise_i(cs_rise_i), .partial_i(partial_i),
  .busy_o(busy_o), .wel_clr_o(wel_clr_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .sr_we_o(sr_we_o)
);

// File: tb/sim_pgw_sequencer.sv
`timescale 1ns/1ps
module sim_pgw_sequencer;
  localparam int PB  = 32;
  localparam int AW  = 13;
  localparam int CYC = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_page_i = 0, ld_byte_i = 0, ld_sr_i = 0, cs_rise_i = 0, partial_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    data_i = '0, sr_data_i = '0;
  logic          busy_o, wel_clr_o, mem_we_o, sr_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wdata_o, sr_wdata_o;

  always #2 clk = ~clk;

  pgw_sequencer #(.PAGE_BYTES(PB), .ADDR_W(AW), .CYCLE_CLKS(CYC)) u0 (
    .clk(clk), .rst(rst), .ld_page_i(ld_page_i), .addr_i(addr_i),
    .ld_byte_i(ld_byte_i), .data_i(data_i), .ld_sr_i(ld_sr_i),
    .sr_data_i(sr_data_i), .cs_rise_i(cs_rise_i), .partial_i(partial_i),
    .busy_o(busy_o), .wel_clr_o(wel_clr_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .sr_we_o(sr_we_o), .sr_wdata_o(sr_wdata_o)
  );

  int checks = 0;
  int errors = 0;
  int wel_n  = 0;

  logic [20:0] exp_q[$];
  logic [7:0]  exp_sr_q[$];

  // reference model of the loading side
  logic [7:0]    m_buf [PB];
  logic [PB-1:0] m_mask = '0;
  logic [7:0]    m_page = '0;
  logic [4:0]    m_off  = '0;
  logic          m_srp  = 1'b0;
  logic [7:0]    m_sr   = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe_page(input logic [AW-1:0] a);
    @(negedge clk);
    if (!busy_o) begin m_page = a[12:5]; m_off = a[4:0]; m_mask = '0; m_srp = 0; end
    addr_i = a; ld_page_i = 1;
    @(posedge clk); #1 ld_page_i = 0;
  endtask

  task automatic strobe_byte(input logic [7:0] d);
    @(negedge clk);
    if (!busy_o) begin m_buf[m_off] = d; m_mask[m_off] = 1'b1; m_off = m_off + 1'b1; end
    data_i = d; ld_byte_i = 1;
    @(posedge clk); #1 ld_byte_i = 0;
  endtask

  task automatic strobe_sr(input logic [7:0] d);
    @(negedge clk);
    if (!busy_o) begin m_srp = 1; m_sr = d; end
    sr_data_i = d; ld_sr_i = 1;
    @(posedge clk); #1 ld_sr_i = 0;
  endtask

  // release; expects a start only when idle, aligned and something loaded
  task automatic release_cs(input bit part, input string req);
    bit start;
    @(negedge clk);
    start = !busy_o && !part && ((m_mask != 0) || m_srp);
    if (!busy_o) begin
      if (start) begin
        if (m_srp) exp_sr_q.push_back(m_sr);
        for (int i = 0; i < PB; i++)
          if (m_mask[i]) exp_q.push_back({m_page, i[4:0], m_buf[i]});
      end
      m_mask = '0; m_srp = 0;
    end
    partial_i = part; cs_rise_i = 1;
    @(posedge clk); #1 cs_rise_i = 0; partial_i = 0;
    @(negedge clk);
    if (start) chk(busy_o === 1'b1, req, busy_o, 1);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic quiet(input string req, input int w0);
    repeat (6) @(negedge clk);
    chk(busy_o === 1'b0, req, busy_o, 0);
    chk(wel_n == w0, req, wel_n, w0);
  endtask

  // monitor: pops expected stores and checks cycle framing
  int bcnt = 0;
  bit prev_b = 0;
  always @(negedge clk) begin
    if (rst) begin
      bcnt = 0; prev_b = 0;
    end else begin
      if (mem_we_o) begin
        chk(busy_o === 1'b1, "R12 store outside busy", busy_o, 1);
        if (exp_q.size() == 0) chk(0, "R4 unexpected store", mem_addr_o, 0);
        else begin
          logic [20:0] e;
          e = exp_q.pop_front();
          chk(mem_addr_o === e[20:8], "R2/R4 store address", mem_addr_o, e[20:8]);
          chk(mem_wdata_o === e[7:0], "R3/R4 store data", mem_wdata_o, e[7:0]);
          if (bcnt == 0) chk(0, "R4 store in first busy cycle", bcnt, 1);
        end
      end
      if (sr_we_o) begin
        chk(bcnt == 0, "R10 status strobe cycle", bcnt, 0);
        if (exp_sr_q.size() == 0) chk(0, "R10 unexpected status store", sr_wdata_o, 0);
        else begin
          logic [7:0] s;
          s = exp_sr_q.pop_front();
          chk(sr_wdata_o === s, "R10 status data", sr_wdata_o, s);
        end
      end
      if (wel_clr_o) begin
        wel_n++;
        chk(prev_b && !busy_o, "R9 latch clear timing", busy_o, 0);
      end
      if (prev_b && !busy_o) begin
        chk(bcnt == CYC, "R8 busy length", bcnt, CYC);
        chk(wel_clr_o === 1'b1, "R9 latch clear on fall", wel_clr_o, 1);
      end
      if (busy_o) bcnt++; else bcnt = 0;
      prev_b = busy_o;
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy_o === 0, "R1 busy", busy_o, 0);
    chk(wel_clr_o === 0, "R1 wel_clr", wel_clr_o, 0);
    chk(mem_we_o === 0 && sr_we_o === 0, "R1 strobes", mem_we_o, 0);

    // R2/R5: single byte write, page kept from upper address bits
    strobe_page(13'h1234);
    strobe_byte(8'hA5);
    release_cs(0, "R5 start after clean release");
    wait_idle();
    chk(exp_q.size() == 0, "R4 all stores seen", exp_q.size(), 0);

    // R3/R4: load across the page end, commit in ascending offset order
    strobe_page(13'h0A5E);
    for (int i = 0; i < 5; i++) strobe_byte(8'h10 + 8'(i));
    release_cs(0, "R5 start page wrap");
    wait_idle();
    chk(exp_q.size() == 0, "R3 wrapped stores seen", exp_q.size(), 0);

    // R3: 34 bytes overwrite offsets 0 and 1
    strobe_page(13'h1FE0);
    for (int i = 0; i < 34; i++) strobe_byte(8'(8'hC0 ^ i));
    release_cs(0, "R5 start full page");
    wait_idle();
    chk(exp_q.size() == 0, "R3 overwrite stores seen", exp_q.size(), 0);

    // R6: release inside a byte aborts and discards
    w = wel_n;
    strobe_page(13'h0040);
    strobe_byte(8'h77);
    release_cs(1, "R6");
    quiet("R6 partial release", w);
    release_cs(0, "R6");
    quiet("R6 nothing left pending", w);

    // R7: start strobe with no data
    strobe_page(13'h0100);
    release_cs(0, "R7");
    quiet("R7 no data byte", w);

    // R10: status write uses the same cycle
    strobe_sr(8'h8C);
    release_cs(0, "R10 start status write");
    wait_idle();
    chk(exp_sr_q.size() == 0, "R10 status store seen", exp_sr_q.size(), 0);
    chk(wel_n == w + 1, "R9 one pulse per cycle", wel_n, w + 1);

    // R11: strobes during a cycle are dropped
    strobe_page(13'h0300);
    strobe_byte(8'h5A);
    release_cs(0, "R11 start");
    strobe_page(13'h0400);
    strobe_byte(8'h11);
    strobe_sr(8'h22);
    release_cs(0, "R11");
    wait_idle();
    w = wel_n;
    release_cs(0, "R11");
    quiet("R11 loads during busy ignored", w);
    chk(exp_q.size() == 0 && exp_sr_q.size() == 0, "R11 no extra stores",
        exp_q.size() + exp_sr_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule